// File: doc/BRIEF.md
# Numerically Controlled Square-Wave Counter

This block makes a square wave from a phase accumulator. A 32-bit increment register is added to a 32-bit phase accumulator on every system clock. In the single-ended oscillator mode, the accumulator's most significant bit drives one pin of a small output port. A six-bit field in the control register selects the pin, and a per-pin enable register gates it. The output frequency is increment × f_clk / 2^32.

Edges can only fall on clock boundaries. When the ideal clock-to-period ratio is fractional, successive periods therefore take the two nearest integer lengths in a repeating pattern. The long-run average of that pattern equals the ideal ratio. For example, the ratio 80e6/46875 = 1706⅔ is served by a repeating pattern of two 1707-clock periods and one 1706-clock period.

Software reaches the block through a simple register port. Writes are strobed and take one cycle. Reads are combinational. The control register also holds a three-bit divider field that is kept for other counter modes: it is stored and read back, and it does not change the oscillator. Any mode code other than the single-ended oscillator code holds every pin low.

Top module: `nco_square_gen`

## Requirements
- R1: While `rst_n` is low at a clock edge, the control, increment, accumulator and pin-enable registers are cleared. After reset, every register reads zero and `pin_out` is all zero.
- R2: On every clock without an accumulator write, the accumulator takes its old value plus the increment, modulo 2^32. A write to the increment register takes effect from the following cycle. In the write cycle itself, the old increment is added.
- R3: A write to address 2 loads the accumulator with `reg_wdata` in that cycle, and no increment is added in that cycle.
- R4: The mode field is control bits 30..26. With code 5'b00100, the selected pin equals accumulator bit 31. Every other code, including 5'b00000 and 5'b00010, holds all of `pin_out` low.
- R5: Control bits 5..0 give the pin index. A value of `NUM_PINS` or more drives no pin, and pins other than the selected one stay low.
- R6: The selected pin is driven only while its bit in the pin-enable register (address 3, bits `NUM_PINS`-1..0) is set. Otherwise the pin is low.
- R7: Control bits 25..23 are a divider field. The field is stored and read back, and it has no effect on `pin_out`.
- R8: The register map is: address 0 is control, address 1 is increment, address 2 is accumulator, address 3 is pin enable. A control read returns only bits 30..23 and 5..0, and all other bits read as zero.
- R9: With increment 2516582 and the phase loaded to zero, each of the first 60 rising-to-rising output periods is 1706 or 1707 clocks, and every three consecutive periods sum to 5120 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 control, 1 increment, 2 accumulator, 3 pin enable) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| pin_out | output | NUM_PINS | Output port vector |

## Verification
The per-clock addition and a software write can land on the accumulator in the same cycle. The same is true of the addition and a write to the increment register. The bench provokes both collisions with directed writes and with a random mix of register writes. A cycle-accurate bench model judges the result: a loaded value must appear without the increment added, and a new increment may only be used from the following cycle. The model also predicts `pin_out` on every cycle, so a collision that corrupts the phase also shows up at the pins.

// File: rtl/nco_pkg.sv
// Shared constants and types for the square-wave counter.
// Assumes a 32-bit register port and a 32-bit phase accumulator.
package nco_pkg;

    localparam int DATA_W   = 32;
    localparam int MODE_LSB = 26;
    localparam int MODE_W   = 5;
    localparam int DIV_LSB  = 23;
    localparam int DIV_W    = 3;
    localparam int SEL_W    = 6;

    localparam logic [MODE_W-1:0] MODE_NCO_SE = 5'b00100;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_INCR = 2'd1;
    localparam logic [1:0] ADDR_ACC  = 2'd2;
    localparam logic [1:0] ADDR_DIR  = 2'd3;

    typedef struct packed {
        logic [MODE_W-1:0] mode;
        logic [DIV_W-1:0]  div;
        logic [SEL_W-1:0]  sel;
    } ctrl_t;

endpackage

// File: rtl/nco_reg_bank.sv
// Register bank: holds control, increment and pin-enable registers,
// decodes the accumulator load strobe and muxes read data.
// Assumes NUM_PINS <= DATA_W so the enable register fits one word.
module nco_reg_bank
    import nco_pkg::*;
#(
    parameter int NUM_PINS = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we,
    input  logic [1:0]          addr,
    input  logic [DATA_W-1:0]   wdata,
    input  logic [DATA_W-1:0]   acc_val,
    output ctrl_t               ctrl,
    output logic [DATA_W-1:0]   incr,
    output logic [NUM_PINS-1:0] dir,
    output logic                acc_load,
    output logic [DATA_W-1:0]   rdata
);

    localparam int PAD_W = DATA_W - NUM_PINS;

    // Decode the accumulator load strobe.
    assign acc_load = we && (addr == ADDR_ACC);

    // Capture register writes; synchronous active-low clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= '0;
            incr <= '0;
            dir  <= '0;
        end else if (we) begin
            case (addr)
                ADDR_CTRL: begin
                    ctrl.mode <= wdata[MODE_LSB +: MODE_W];
                    ctrl.div  <= wdata[DIV_LSB +: DIV_W];
                    ctrl.sel  <= wdata[SEL_W-1:0];
                end
                ADDR_INCR: incr <= wdata;
                ADDR_DIR:  dir  <= wdata[NUM_PINS-1:0];
                default: ;
            endcase
        end
    end

    // Select read data; unused control bits read as zero.
    always_comb begin
        rdata = '0;
        case (addr)
            ADDR_CTRL: begin
                rdata[MODE_LSB +: MODE_W] = ctrl.mode;
                rdata[DIV_LSB +: DIV_W]   = ctrl.div;
                rdata[SEL_W-1:0]          = ctrl.sel;
            end
            ADDR_INCR: rdata = incr;
            ADDR_ACC:  rdata = acc_val;
            default:   rdata = {{PAD_W{1'b0}}, dir};
        endcase
    end

    // R1: reset leaves every register cleared
    a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (ctrl == '0 && incr == '0 && dir == '0));

    // R7: the divider field keeps the value last written
    a_r7_div_capture: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(we) && $past(addr) == ADDR_CTRL)
        |-> ctrl.div == $past(wdata[DIV_LSB +: DIV_W]));

endmodule

// File: rtl/nco_phase_acc.sv
// Phase accumulator: adds the increment every clock and wraps modulo
// 2^ACC_W. A load replaces the sum for that cycle.
module nco_phase_acc #(
    parameter int ACC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [ACC_W-1:0] load_val,
    input  logic [ACC_W-1:0] incr,
    output logic [ACC_W-1:0] acc
);

    // Advance the phase or load it; synchronous active-low clear.
    always_ff @(posedge clk) begin
        if (!rst_n)    acc <= '0;
        else if (load) acc <= load_val;
        else           acc <= acc + incr;
    end

    // R2: without a load the phase advances by the old increment
    a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(load)) |-> acc == $past(acc) + $past(incr));

    // R3: a load wins over the addition
    a_r3_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(load)) |-> acc == $past(load_val));

endmodule

// File: rtl/nco_pin_router.sv
// Mode decoder and pin router: in single-ended oscillator mode, sends the
// phase MSB to the selected pin if that pin is enabled. All other pins,
// and all pins in every other mode, stay low.
module nco_pin_router
    import nco_pkg::*;
#(
    parameter int NUM_PINS = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [MODE_W-1:0]   mode,
    input  logic [SEL_W-1:0]    sel,
    input  logic [NUM_PINS-1:0] dir,
    input  logic                phase_msb,
    output logic [NUM_PINS-1:0] pin_out
);

    logic osc_on;

    // Recognise the only implemented mode code.
    assign osc_on = (mode == MODE_NCO_SE);

    // Build one gated pin driver per output.
    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        assign pin_out[i] = osc_on && (sel == SEL_W'(i)) && dir[i] && phase_msb;
    end

    // R4: unimplemented modes keep the port low
    a_r4_mode_off_low: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != MODE_NCO_SE) |-> pin_out == '0);

    // R5: at most one pin is active
    a_r5_single_pin: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pin_out));

    // R6: only enabled pins may be high
    a_r6_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_out & ~dir) == '0);

endmodule

// File: rtl/nco_square_gen.sv
// Top level of the square-wave counter: register bank, phase accumulator
// and pin router. Assumes NUM_PINS <= 32 and a synchronous active-low reset.
module nco_square_gen
    import nco_pkg::*;
#(
    parameter int NUM_PINS = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_we,
    input  logic [1:0]          reg_addr,
    input  logic [31:0]         reg_wdata,
    output logic [31:0]         reg_rdata,
    output logic [NUM_PINS-1:0] pin_out
);

    ctrl_t               ctrl;
    logic [DATA_W-1:0]   incr;
    logic [DATA_W-1:0]   acc;
    logic [NUM_PINS-1:0] dir;
    logic                acc_load;

    nco_reg_bank #(.NUM_PINS(NUM_PINS)) regs_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (reg_we),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .acc_val  (acc),
        .ctrl     (ctrl),
        .incr     (incr),
        .dir      (dir),
        .acc_load (acc_load),
        .rdata    (reg_rdata)
    );

    nco_phase_acc #(.ACC_W(DATA_W)) acc_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (acc_load),
        .load_val (reg_wdata),
        .incr     (incr),
        .acc      (acc)
    );

    nco_pin_router #(.NUM_PINS(NUM_PINS)) route_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (ctrl.mode),
        .sel       (ctrl.sel),
        .dir       (dir),
        .phase_msb (acc[DATA_W-1]),
        .pin_out   (pin_out)
    );

endmodule

// File: tb/nco_square_gen_tb_top.sv
// Self-checking bench: a bench model predicts the registers and pins every
// cycle, with directed corner cases and seeded random register traffic.
// Clock: 8 time units per period (125 MHz at 1 ns units).
module nco_square_gen_tb_top;

    localparam int NP = 32;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          reg_we;
    logic [1:0]    reg_addr;
    logic [31:0]   reg_wdata;
    logic [31:0]   reg_rdata;
    logic [NP-1:0] pin_out;

    always #4 clk = ~clk;

    nco_square_gen #(.NUM_PINS(NP)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .pin_out   (pin_out)
    );

    int checks = 0;
    int bads   = 0;
    int cyc    = 0;
    bit done   = 0;

    logic [4:0]    m_mode;
    logic [2:0]    m_div;
    logic [5:0]    m_sel;
    logic [31:0]   m_incr;
    logic [31:0]   m_acc;
    logic [NP-1:0] m_dir;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            bads++;
            $display("FAIL %s cycle=%0d actual=%h expected=%h", tag, cyc, act, exp);
        end
    endtask

    function automatic logic [NP-1:0] exp_pins();
        logic [NP-1:0] r;
        r = '0;
        if (m_mode == 5'b00100 && m_sel < NP && m_dir[m_sel[4:0]])
            r[m_sel[4:0]] = m_acc[31];
        return r;
    endfunction

    function automatic logic [31:0] exp_rd(input logic [1:0] a);
        case (a)
            2'd0:    return {1'b0, m_mode, m_div, 17'b0, m_sel};
            2'd1:    return m_incr;
            2'd2:    return m_acc;
            default: return 32'(m_dir);
        endcase
    endfunction

    // One clock: update the model from the driven inputs, then compare the pins.
    task automatic tick(input string tag);
        logic [31:0] nacc;
        nacc = m_acc + m_incr;
        if (reg_we) begin
            case (reg_addr)
                2'd0: begin
                    m_mode = reg_wdata[30:26];
                    m_div  = reg_wdata[25:23];
                    m_sel  = reg_wdata[5:0];
                end
                2'd1: m_incr = reg_wdata;
                2'd2: nacc   = reg_wdata;
                default: m_dir = reg_wdata[NP-1:0];
            endcase
        end
        m_acc = nacc;
        @(posedge clk);
        @(negedge clk);
        reg_we = 1'b0;
        cyc++;
        chk(tag, 64'(pin_out), 64'(exp_pins()));
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d, input string tag);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        tick(tag);
    endtask

    task automatic rd_chk(input logic [1:0] a, input string tag);
        reg_addr = a;
        #1;
        chk(tag, 64'(reg_rdata), 64'(exp_rd(a)));
    endtask

    function automatic logic [31:0] ctrl_word(input logic [4:0] md, input logic [2:0] dv,
                                              input logic [5:0] sl);
        return {1'b0, md, dv, 17'b0, sl};
    endfunction

    // Watchdog: an expired run counts as a failed check.
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            bads++;
            $display("FAIL watchdog expired at cycle=%0d", cyc);
            $display("  test done: total=%0d bad=%0d", checks, bads);
            $finish;
        end
    end

    initial begin
        int per [0:59];
        int rises;
        int last;
        logic prev;
        void'($urandom(32'd7411));
        rst_n = 1'b0; reg_we = 1'b0; reg_addr = 2'd0; reg_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_mode = '0; m_div = '0; m_sel = '0; m_incr = '0; m_acc = '0; m_dir = '0;

        // R1: reset state
        for (int a = 0; a < 4; a++) begin
            reg_addr = 2'(a); #1;
            chk("R1 reset read", 64'(reg_rdata), 64'd0);
        end
        chk("R1 reset pins", 64'(pin_out), 64'd0);

        // R8: control readback masks unused bits (R7 divider kept)
        wr(2'd0, 32'hFFFF_FFFF, "R8");
        reg_addr = 2'd0; #1;
        chk("R8 ctrl mask", 64'(reg_rdata), 64'h7F80_003F);
        chk("R7 div readback", 64'(reg_rdata[25:23]), 64'd7);

        // R3 and R2: load collides with addition; increment write uses old value
        wr(2'd1, 32'd100, "R2");
        wr(2'd2, 32'd5, "R3");
        reg_addr = 2'd2; #1;
        chk("R3 load wins", 64'(reg_rdata), 64'd5);
        tick("R2");
        rd_chk(2'd2, "R2 step");
        chk("R2 value", 64'(reg_rdata), 64'd105);
        wr(2'd1, 32'd7, "R2");
        rd_chk(2'd2, "R2 old incr in write cycle");
        chk("R2 old incr", 64'(reg_rdata), 64'd205);
        tick("R2");
        chk("R2 new incr", 64'(dut_i.reg_rdata), 64'd212);

        // R2: wrap modulo 2^32
        wr(2'd1, 32'h20, "R2");
        wr(2'd2, 32'hFFFF_FFF0, "R3");
        tick("R2");
        rd_chk(2'd2, "R2 wrap");
        chk("R2 wrap value", 64'(reg_rdata), 64'h10);

        // R4/R5/R6: phase held high, then vary mode, select and enable
        wr(2'd1, 32'd0, "R2");
        wr(2'd2, 32'h8000_0000, "R3");
        wr(2'd3, 32'hFFFF_FFFF, "R6");
        wr(2'd0, ctrl_word(5'b00100, 3'd0, 6'd9), "R4");
        chk("R4 nco pin high", 64'(pin_out), 64'(32'h200));
        wr(2'd0, ctrl_word(5'b00100, 3'd5, 6'd9), "R7");
        chk("R7 div no effect", 64'(pin_out), 64'(32'h200));
        wr(2'd0, ctrl_word(5'b00010, 3'd4, 6'd9), "R4");
        chk("R4 pll code low", 64'(pin_out), 64'd0);
        wr(2'd0, ctrl_word(5'b00000, 3'd0, 6'd9), "R4");
        chk("R4 mode zero low", 64'(pin_out), 64'd0);
        wr(2'd0, ctrl_word(5'b00100, 3'd0, 6'd40), "R5");
        chk("R5 out-of-range select", 64'(pin_out), 64'd0);
        wr(2'd0, ctrl_word(5'b00100, 3'd0, 6'd31), "R5");
        chk("R5 top pin", 64'(pin_out), 64'(32'h8000_0000));
        wr(2'd3, 32'h7FFF_FFFF, "R6");
        chk("R6 disabled pin low", 64'(pin_out), 64'd0);

        // Random register traffic against the bench model
        for (int k = 0; k < 400; k++) begin
            int op;
            op = $urandom_range(0, 4);
            case (op)
                0: begin
                    logic [4:0] md;
                    int pick;
                    pick = $urandom_range(0, 3);
                    md = (pick == 0) ? 5'b00000 : (pick == 1) ? 5'b00100 :
                         (pick == 2) ? 5'b00010 : 5'($urandom);
                    wr(2'd0, ctrl_word(md, 3'($urandom), 6'($urandom_range(0, 40))), "R4");
                end
                1: wr(2'd1, $urandom, "R2");
                2: wr(2'd2, $urandom, "R3");
                3: wr(2'd3, $urandom, "R6");
                default: tick("R5");
            endcase
            repeat ($urandom_range(0, 3)) tick("R2");
            rd_chk(2'($urandom_range(0, 3)), "R8 random read");
        end

        // R9: fractional ratio 1706 2/3 from phase zero
        wr(2'd3, 32'h0000_0080, "R6");
        wr(2'd0, ctrl_word(5'b00100, 3'd0, 6'd7), "R9");
        wr(2'd1, 32'd2516582, "R9");
        wr(2'd2, 32'd0, "R9");
        prev = pin_out[7];
        rises = 0;
        last = 0;
        while (rises < 61) begin
            tick("R9");
            if (pin_out[7] && !prev) begin
                if (rises > 0) per[rises-1] = cyc - last;
                last = cyc;
                rises++;
            end
            prev = pin_out[7];
        end
        for (int p = 0; p < 60; p++) begin
            checks++;
            if (per[p] != 1706 && per[p] != 1707) begin
                bads++;
                $display("FAIL R9 period %0d actual=%0d expected=1706 or 1707", p, per[p]);
            end
        end
        for (int p = 0; p + 2 < 60; p++)
            chk("R9 triplet sum", 64'(per[p] + per[p+1] + per[p+2]), 64'd5120);

        done = 1;
        $display("  test done: total=%0d bad=%0d", checks, bads);
        $finish;
    end

endmodule